// File: doc/BRIEF.md
# Split-Phase Programmable Clock Divider

This block divides an input clock by an integer ratio that is set while it runs. The ratio is not stored as one number. It is stored as two phase counts: the number of input cycles the output spends high, and the number it spends low. Two flags complete the setting. The half-cycle flag lengthens the high phase by half an input period and shortens the low phase by the same amount, so an odd ratio gives a duty cycle as close to even as possible. The pass-through flag forwards the input clock directly, with no counting.

Software loads settings through a small write port. The port has three formats: a phase word, a flag word, and a packed word that carries all four fields at once. Each write goes into a staging copy. The divider adopts the staged setting only when its output is about to rise, so a change never cuts a pulse short. The setting in use is reported as an effective ratio, which is the high span plus the low span.

Top module: `dclk_divider`

## Requirements
- R1: After reset the active setting is 1 high cycle and 1 low cycle with both flags clear: `eff_ratio` reads 2 and the output period is two input cycles.
- R2: A write with `cfg_sel`=0 loads the low count from `cfg_wdata[5:0]` and the high count from `cfg_wdata[11:6]`. The flags are unchanged. With both flags clear, the output is high for exactly H input cycles and low for exactly L input cycles.
- R3: A write with `cfg_sel`=1 loads the half-cycle flag from `cfg_wdata[7]` and the pass-through flag from `cfg_wdata[6]`. The counts are unchanged.
- R4: A write with `cfg_sel`=2 loads all fields at once: half-cycle flag in bit 13, pass-through flag in bit 12, high count in bits 11:6, low count in bits 5:0.
- R5: A count field of 0 stands for 64, so ratios up to 128 are reachable.
- R6: With the half-cycle flag set, the output is high for H+½ input cycles and low for L−½ input cycles. H=1, L=2 gives 1.5/1.5, and H=2, L=2 gives 2.5/1.5.
- R7: With the pass-through flag set, the output follows the input clock. Clearing the flag returns the output to counting with the staged counts.
- R8: A new setting takes effect only at the next rising edge of the output. The phase in progress when the write lands finishes with the old setting.
- R9: `eff_ratio` equals the sum of the high and low spans of the active setting, or 1 when pass-through is active. It changes only when a new setting is adopted.
- R10: A write with `cfg_sel`=3 changes nothing.
- R11: While `rst` is high the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Clock to be divided; also clocks the write port |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the setting port |
| cfg_sel | input | 2 | Write format: 0 phase word, 1 flag word, 2 packed word, 3 unused |
| cfg_wdata | input | 16 | Write data |
| clk_out | output | 1 | Divided clock |
| eff_ratio | output | 8 | Effective ratio of the active setting |

## Verification
The output is measured as high and low run lengths in half input periods, so each ratio is checked as an exact pair of numbers. Ratios 2 and 8 with equal and unequal phases separate the high count from the low count. Odd and even ratios with the half-cycle flag show whether the half period is moved from the low phase to the high phase, and not just added to one of them. The all-zero and 64+1 packed words check that a zero field means 64. Pass-through on and off, an unused-format write, and a write that lands in the middle of a long high phase show that settings are adopted only at an output rising edge.

// File: rtl/dclk_pkg.sv
package dclk_pkg;

    localparam int FIELD_W  = 6;
    localparam int CNT_W    = FIELD_W + 1;
    localparam int RATIO_W  = FIELD_W + 2;
    localparam int CFG_W    = 16;

    // field positions decoded by the setting port
    localparam int PH_LO_LSB   = 0;
    localparam int PH_HI_LSB   = 6;
    localparam int FL_HALF_BIT = 7;
    localparam int FL_PASS_BIT = 6;
    localparam int PK_HALF_BIT = 13;
    localparam int PK_PASS_BIT = 12;

    typedef enum logic [1:0] {
        SEL_PHASE  = 2'd0,
        SEL_FLAGS  = 2'd1,
        SEL_PACKED = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic               half_adj;
        logic               pass;
        logic [FIELD_W-1:0] hi_f;
        logic [FIELD_W-1:0] lo_f;
    } div_set_t;

    // a zero field encodes the largest span
    function automatic logic [CNT_W-1:0] field_span(input logic [FIELD_W-1:0] f);
        if (f == '0) return {1'b1, {FIELD_W{1'b0}}};
        return {1'b0, f};
    endfunction

    function automatic div_set_t make_set(input int hi, input int lo);
        div_set_t s;
        s.half_adj = 1'b0;
        s.pass     = 1'b0;
        s.hi_f     = FIELD_W'(hi);
        s.lo_f     = FIELD_W'(lo);
        return s;
    endfunction

endpackage

// File: rtl/dclk_cfg_regs.sv
module dclk_cfg_regs
    import dclk_pkg::*;
#(
    parameter int RST_HI = 1,
    parameter int RST_LO = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       sel,
    input  logic [CFG_W-1:0] wdata,
    output div_set_t         staged
);

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= make_set(RST_HI, RST_LO);
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_PHASE: begin
                    staged.hi_f <= wdata[PH_HI_LSB +: FIELD_W];
                    staged.lo_f <= wdata[PH_LO_LSB +: FIELD_W];
                end
                SEL_FLAGS: begin
                    staged.half_adj <= wdata[FL_HALF_BIT];
                    staged.pass     <= wdata[FL_PASS_BIT];
                end
                SEL_PACKED: begin
                    staged.half_adj <= wdata[PK_HALF_BIT];
                    staged.pass     <= wdata[PK_PASS_BIT];
                    staged.hi_f     <= wdata[PH_HI_LSB +: FIELD_W];
                    staged.lo_f     <= wdata[PH_LO_LSB +: FIELD_W];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dclk_counter.sv
module dclk_counter
    import dclk_pkg::*;
#(
    parameter int RST_HI = 1,
    parameter int RST_LO = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  div_set_t         staged,
    output div_set_t         active,
    output logic             div_q,
    output logic [CNT_W-1:0] cnt,
    output logic             commit
);

    logic low_done;
    logic high_done;

    // cnt holds the cycles left in the current phase, including this one
    assign low_done  = !div_q && (cnt <= CNT_W'(1));
    assign high_done =  div_q && (cnt == CNT_W'(1));
    assign commit    = !rst && (active.pass || low_done);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= make_set(RST_HI, RST_LO);
            div_q  <= 1'b0;
            cnt    <= '0;
        end else if (commit) begin
            active <= staged;
            if (staged.pass) begin
                div_q <= 1'b0;
                cnt   <= '0;
            end else begin
                div_q <= 1'b1;
                cnt   <= field_span(staged.hi_f);
            end
        end else if (high_done) begin
            div_q <= 1'b0;
            cnt   <= field_span(active.lo_f);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

endmodule

// File: rtl/dclk_outstage.sv
module dclk_outstage
    import dclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     div_q,
    input  div_set_t active,
    output logic     clk_out
);

    logic neg_q;

    // copy of the divided level taken half a period late
    always_ff @(negedge clk) begin
        if (rst) neg_q <= 1'b0;
        else     neg_q <= div_q;
    end

    always_comb begin
        if (rst)              clk_out = 1'b0;
        else if (active.pass) clk_out = clk;
        else                  clk_out = div_q | (active.half_adj & neg_q);
    end

endmodule

// File: rtl/dclk_divider.sv
module dclk_divider
    import dclk_pkg::*;
#(
    parameter int RST_HI = 1,
    parameter int RST_LO = 1
) (
    input  logic               clk_in,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic               clk_out,
    output logic [RATIO_W-1:0] eff_ratio
);

    div_set_t         staged;
    div_set_t         active;
    logic             div_q;
    logic [CNT_W-1:0] cnt;
    logic             commit;

    dclk_cfg_regs #(.RST_HI(RST_HI), .RST_LO(RST_LO)) u_cfg (
        .clk    (clk_in),
        .rst    (rst),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .staged (staged)
    );

    dclk_counter #(.RST_HI(RST_HI), .RST_LO(RST_LO)) u_cnt (
        .clk    (clk_in),
        .rst    (rst),
        .staged (staged),
        .active (active),
        .div_q  (div_q),
        .cnt    (cnt),
        .commit (commit)
    );

    dclk_outstage u_out (
        .clk     (clk_in),
        .rst     (rst),
        .div_q   (div_q),
        .active  (active),
        .clk_out (clk_out)
    );

    always_comb begin
        if (active.pass)
            eff_ratio = RATIO_W'(1);
        else
            eff_ratio = RATIO_W'(field_span(active.hi_f)) + RATIO_W'(field_span(active.lo_f));
    end

endmodule

// File: rtl/dclk_divider_chk.sv
module dclk_divider_chk
    import dclk_pkg::*;
(
    input logic               clk_in,
    input logic               rst,
    input logic               clk_out,
    input logic [RATIO_W-1:0] eff_ratio,
    input logic               commit,
    input logic               div_q,
    input logic [CNT_W-1:0]   cnt
);

    assert_low_in_reset_R11: assert property (@(posedge clk_in)
        rst |-> !clk_out);

    assert_ratio_moves_on_commit_R9: assert property (@(posedge clk_in) disable iff (rst)
        !$stable(eff_ratio) |-> $past(commit));

    assert_rise_only_on_commit_R8: assert property (@(posedge clk_in) disable iff (rst)
        $rose(div_q) |-> $past(commit));

    assert_span_in_range_R5: assert property (@(posedge clk_in) disable iff (rst)
        cnt <= CNT_W'(64));

endmodule

bind dclk_divider dclk_divider_chk u_chk (
    .clk_in    (clk_in),
    .rst       (rst),
    .clk_out   (clk_out),
    .eff_ratio (eff_ratio),
    .commit    (commit),
    .div_q     (div_q),
    .cnt       (cnt)
);

// File: tb/dclk_divider_test.sv
module dclk_divider_test;

    // 10-unit period: 100 MHz with 1 ns units
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [15:0] cfg_wdata;
    logic        clk_out;
    logic [7:0]  eff_ratio;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        int    hi;
        int    lo;
        string req;
    } exp_t;
    exp_t exp_q[$];

    event rise_ev;
    logic prev_s   = 1'b0;
    bit   seen     = 1'b0;
    int   run_hi   = 0;
    int   run_lo   = 0;

    always #5 clk = ~clk;

    dclk_divider uut (
        .clk_in    (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .clk_out   (clk_out),
        .eff_ratio (eff_ratio)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // monitor: run lengths in half input periods, one record per full period
    task automatic take_sample();
        logic s;
        s = clk_out;
        if (s && !prev_s) begin
            if (seen && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(run_hi == e.hi, {e.req, " high halves"}, run_hi, e.hi);
                chk(run_lo == e.lo, {e.req, " low halves"}, run_lo, e.lo);
            end
            seen   = 1'b1;
            run_hi = 1;
            run_lo = 0;
            ->rise_ev;
        end else if (s) begin
            run_hi++;
        end else begin
            run_lo++;
        end
        prev_s = s;
    endtask

    initial begin
        forever begin
            @(posedge clk); #2; take_sample();
            @(negedge clk); #2; take_sample();
        end
    end

    function automatic int span(input int f);
        return (f == 0) ? 64 : f;
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // driver: push expected periods once the new setting is surely active
    task automatic expect_set(input int h, input int l, input bit half, input bit pass,
                              input int n, input string req);
        exp_t e;
        int   exp_eff;
        if (pass) begin
            e.hi = 1; e.lo = 1; exp_eff = 1;
        end else begin
            e.hi = 2 * span(h) + (half ? 1 : 0);
            e.lo = 2 * span(l) - (half ? 1 : 0);
            exp_eff = span(h) + span(l);
        end
        e.req = req;
        @(rise_ev);
        @(rise_ev);
        for (int i = 0; i < n; i++) exp_q.push_back(e);
        while (exp_q.size() != 0) @(posedge clk);
        @(negedge clk);
        chk(eff_ratio == 8'(exp_eff), {req, " R9 eff_ratio"}, int'(eff_ratio), exp_eff);
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_up();
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #2;
            chk(clk_out == 1'b0, "R11 out in reset", int'(clk_out), 0);
        end
        @(negedge clk);
        rst = 1'b0;
        chk(eff_ratio == 8'd2, "R1 reset ratio", int'(eff_ratio), 2);
        expect_set(1, 1, 0, 0, 3, "R1 default");

        wr(2'd0, 16'((3 << 6) | 5));
        expect_set(3, 5, 0, 0, 2, "R2 phase word");

        wr(2'd3, 16'hffff);
        expect_set(3, 5, 0, 0, 2, "R10 unused format");

        wr(2'd0, 16'((1 << 6) | 2));
        wr(2'd1, 16'(1 << 7));
        expect_set(1, 2, 1, 0, 3, "R3 flag word odd");

        wr(2'd0, 16'((2 << 6) | 2));
        expect_set(2, 2, 1, 0, 2, "R6 half on even");

        wr(2'd2, 16'((1 << 13) | (2 << 6) | 3));
        expect_set(2, 3, 1, 0, 2, "R4 packed word");

        wr(2'd2, 16'h0000);
        expect_set(0, 0, 0, 0, 2, "R5 ratio 128");

        wr(2'd2, 16'h0001);
        expect_set(0, 1, 0, 0, 2, "R5 high 64");

        wr(2'd1, 16'(1 << 6));
        expect_set(0, 1, 0, 1, 4, "R7 pass through");

        wr(2'd1, 16'h0000);
        expect_set(0, 1, 0, 0, 2, "R7 pass cleared");

        wr(2'd2, 16'((10 << 6) | 10));
        expect_set(10, 10, 0, 0, 1, "R8 long ratio");
        @(rise_ev);
        wr(2'd0, 16'((2 << 6) | 2));
        chk(eff_ratio == 8'd20, "R8 old setting kept", int'(eff_ratio), 20);
        chk(clk_out == 1'b1, "R8 high phase intact", int'(clk_out), 1);
        @(rise_ev);
        @(negedge clk);
        chk(eff_ratio == 8'd4, "R8 adopted at rise", int'(eff_ratio), 4);
        expect_set(2, 2, 0, 0, 2, "R8 new ratio");

        finish_up();
    end

endmodule